// File: doc/BRIEF.md
# Single-Butterfly 64-Point Inverse FFT Engine

This block turns one frame of 64 complex frequency-domain samples into 64 complex time-domain samples, the inverse transform an OFDM transmitter needs once per symbol. Area is kept small by building exactly one radix-4 butterfly and reusing it: a 48-step sequence of three radix-4 passes, each made of 16 butterfly steps, runs over a 64-entry working register, one step per clock.

A producer offers a frame on the input port with a valid/ready handshake. The frame is consumed by the first step, and the engine refuses new frames until the last step has run. The last step places the finished frame in an output register. That register is held with a valid flag until a consumer takes it. If the previous result is still waiting, the last step stalls and every piece of working state stays put.

Top module: `ifft64_sf`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 exactly when the engine is idle, which includes the cycle in which a finished frame first appears on the output.
- R2: A frame is taken at a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` is 0 until the engine finishes that frame.
- R3: Sample n of a frame is carried on bits [16n+15:16n] of `in_re`/`in_im` in signed 16-bit two's complement. Output bin k, on bits [16k+15:16k] of `out_re`/`out_im`, equals (1/64)·Σn x[n]·exp(+j2πnk/64) to within 8 LSB in each part, for inputs whose parts stay within ±8000.
- R4: When the output register is free, `out_valid` rises exactly 47 clock edges after the edge that took the frame: one butterfly step per edge, 48 steps in all.
- R5: When a finished result waits to be taken and the next frame has reached its final step, that step is held. `in_ready` stays 0 and no working state changes until `out_ready` is 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_re`/`out_im` do not change. A frame that is taken with `out_ready` 1 and no new result behind it leaves `out_valid` at 0 on the next cycle.
- R7: If the consumer takes the waiting frame in the same cycle that the final step of the next frame runs, `out_valid` stays 1 with no gap and the output carries the new frame.
- R8: `in_valid` and input data offered while `in_ready` is 0 are ignored. The frame in progress completes unchanged, and no extra frame is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a frame |
| in_ready | output | 1 | Engine idle, a frame may be taken |
| in_re | input | 1024 | Real parts of 64 input samples, sample n at [16n+15:16n] |
| in_im | input | 1024 | Imaginary parts of 64 input samples |
| out_valid | output | 1 | A finished frame is held on the output |
| out_ready | input | 1 | Consumer takes the held frame |
| out_re | output | 1024 | Real parts of 64 output bins, bin k at [16k+15:16k] |
| out_im | output | 1024 | Imaginary parts of 64 output bins |

## Verification
The events most likely to collide are the final butterfly step, which writes a new result into the output register, and the consumer draining the frame already held there. The bench provokes this by holding `out_ready` low while a second frame runs into its stalled final step, then raising `out_ready` for a single cycle. It then judges that `out_valid` never drops, that the output now matches the inverse transform of the second frame, and that the engine is idle again. A second overlap, a new frame taken while the old result still waits, is created in the same sequence. Its result is compared against a floating-point inverse transform computed in the bench.

// File: rtl/ifft_pkg.sv
// Shared constants, the complex sample type and the twiddle lookup for the
// single-butterfly inverse FFT. Assumes Q1.15 twiddles and 16-bit samples.
package ifft_pkg;

    localparam int SAMPLE_W = 16;
    localparam int N_PTS    = 64;
    localparam int RADIX    = 4;
    localparam int N_STAGES = 3;
    localparam int GROUPS   = N_PTS / RADIX;
    localparam int N_STEPS  = N_STAGES * GROUPS;
    localparam int STEP_W   = $clog2(N_STEPS);
    localparam int GRP_W    = $clog2(GROUPS);
    localparam int RAD_W    = $clog2(RADIX);
    localparam int IDX_W    = $clog2(N_PTS);
    localparam int FRAME_W  = N_PTS * SAMPLE_W;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } cplx_t;

    // Quarter-wave cosine in Q1.15: cos(2*pi*m/64) for m = 0..16.
    function automatic logic signed [SAMPLE_W-1:0] cos_q15(input logic [4:0] m);
        case (m)
            5'd0:    return 16'sd32767;
            5'd1:    return 16'sd32609;
            5'd2:    return 16'sd32137;
            5'd3:    return 16'sd31356;
            5'd4:    return 16'sd30273;
            5'd5:    return 16'sd28898;
            5'd6:    return 16'sd27245;
            5'd7:    return 16'sd25329;
            5'd8:    return 16'sd23170;
            5'd9:    return 16'sd20787;
            5'd10:   return 16'sd18204;
            5'd11:   return 16'sd15446;
            5'd12:   return 16'sd12539;
            5'd13:   return 16'sd9512;
            5'd14:   return 16'sd6393;
            5'd15:   return 16'sd3212;
            default: return 16'sd0;
        endcase
    endfunction

    // exp(+j*2*pi*e/64), folded from the quarter-wave table by quadrant.
    function automatic cplx_t twiddle(input logic [IDX_W-1:0] e);
        cplx_t w;
        logic signed [SAMPLE_W-1:0] c;
        logic signed [SAMPLE_W-1:0] s;
        c = cos_q15({1'b0, e[3:0]});
        s = cos_q15(5'd16 - {1'b0, e[3:0]});
        case (e[5:4])
            2'd0:    begin w.re = c;  w.im = s;  end
            2'd1:    begin w.re = -s; w.im = c;  end
            2'd2:    begin w.re = -c; w.im = -s; end
            default: begin w.re = s;  w.im = -c; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ifft_twiddle_sel.sv
// Picks the four input twiddles for the current step. Pass 0 needs none,
// pass 1 uses exponent 4*q*(group div 4), pass 2 uses q*group.
// Assumes the digit-reversed load and the digit-rotate shuffle of the top.
module ifft_twiddle_sel
    import ifft_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output cplx_t             tw [RADIX]
);

    logic [1:0]       stage;
    logic [GRP_W-1:0] grp;

    assign stage = step[STEP_W-1 -: 2];
    assign grp   = step[GRP_W-1:0];

    for (genvar q = 0; q < RADIX; q++) begin : g_lane
        logic [IDX_W-1:0] expo;

        // Exponent of the twiddle applied to butterfly input q.
        always_comb begin
            case (stage)
                2'd0:    expo = '0;
                2'd1:    expo = IDX_W'(q) * {2'b00, grp[GRP_W-1 -: 2], 2'b00};
                default: expo = IDX_W'(q) * {2'b00, grp};
            endcase
        end

        assign tw[q] = twiddle(expo);
    end

endmodule

// File: rtl/ifft_bfly4.sv
// One radix-4 inverse butterfly: rotate each input by its twiddle, form the
// four-point sums with +j rotation, divide by four and saturate to 16 bits.
// Assumes Q1.15 twiddles; truncation rounds toward minus infinity.
module ifft_bfly4
    import ifft_pkg::*;
(
    input  cplx_t a  [RADIX],
    input  cplx_t tw [RADIX],
    output cplx_t y  [RADIX]
);

    localparam int PROD_W = 2 * SAMPLE_W + 1;
    localparam int ROT_W  = SAMPLE_W + 2;
    localparam int SUM_W  = ROT_W + RAD_W;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2 ** (SAMPLE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -MAXV - 1;

    logic signed [SUM_W-1:0] tr [RADIX];
    logic signed [SUM_W-1:0] ti [RADIX];
    logic signed [SUM_W-1:0] sr [RADIX];
    logic signed [SUM_W-1:0] si [RADIX];

    function automatic logic signed [SAMPLE_W-1:0] quarter_sat(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] sh;
        sh = v >>> RAD_W;
        if (sh > MAXV)      return MAXV[SAMPLE_W-1:0];
        else if (sh < MINV) return MINV[SAMPLE_W-1:0];
        else                return sh[SAMPLE_W-1:0];
    endfunction

    for (genvar q = 0; q < RADIX; q++) begin : g_rot
        logic signed [PROD_W-1:0] pr;
        logic signed [PROD_W-1:0] pi;
        logic signed [ROT_W-1:0]  rr;
        logic signed [ROT_W-1:0]  ri;

        assign pr = PROD_W'(a[q].re) * PROD_W'(tw[q].re) - PROD_W'(a[q].im) * PROD_W'(tw[q].im);
        assign pi = PROD_W'(a[q].re) * PROD_W'(tw[q].im) + PROD_W'(a[q].im) * PROD_W'(tw[q].re);
        assign rr = ROT_W'(pr >>> (SAMPLE_W - 1));
        assign ri = ROT_W'(pi >>> (SAMPLE_W - 1));
        assign tr[q] = SUM_W'(rr);
        assign ti[q] = SUM_W'(ri);
    end

    // Four-point sums: output m weights input q by j^(q*m).
    always_comb begin
        sr[0] = tr[0] + tr[1] + tr[2] + tr[3];
        si[0] = ti[0] + ti[1] + ti[2] + ti[3];
        sr[1] = tr[0] - ti[1] - tr[2] + ti[3];
        si[1] = ti[0] + tr[1] - ti[2] - tr[3];
        sr[2] = tr[0] - tr[1] + tr[2] - tr[3];
        si[2] = ti[0] - ti[1] + ti[2] - ti[3];
        sr[3] = tr[0] + ti[1] - tr[2] - ti[3];
        si[3] = ti[0] - tr[1] - ti[2] + tr[3];
    end

    for (genvar m = 0; m < RADIX; m++) begin : g_out
        assign y[m].re = quarter_sat(sr[m]);
        assign y[m].im = quarter_sat(si[m]);
    end

endmodule

// File: rtl/ifft_step_ctrl.sv
// Step counter and handshake decisions. Step 0 waits for a frame, steps
// 1..46 run freely, and the final step waits until the output register is
// free or is being emptied. Assumes out_valid comes from the top's register.
module ifft_step_ctrl
    import ifft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_valid,
    input  logic              out_ready,
    output logic [STEP_W-1:0] step,
    output logic              in_ready,
    output logic              adv,
    output logic              last_adv
);

    logic at_last;

    // Decide whether the current step runs in this cycle.
    always_comb begin
        at_last  = (step == STEP_W'(N_STEPS - 1));
        in_ready = (step == '0);
        if (in_ready)     adv = in_valid;
        else if (at_last) adv = !out_valid || out_ready;
        else              adv = 1'b1;
        last_adv = at_last && adv;
    end

    // Advance the step index, wrapping after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n)   step <= '0;
        else if (adv) step <= at_last ? '0 : step + 1'b1;
    end

endmodule

// File: rtl/ifft64_sf.sv
// 64-point inverse FFT built on one shared radix-4 butterfly, 48 steps per
// frame. Input is loaded digit-reversed; after every 16th step the vector is
// digit-rotated so each pass sees its butterfly inputs in adjacent entries,
// and the third rotation leaves bins in natural order. Output is scaled 1/64.
module ifft64_sf
    import ifft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FRAME_W-1:0] in_re,
    input  logic [FRAME_W-1:0] in_im,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FRAME_W-1:0] out_re,
    output logic [FRAME_W-1:0] out_im
);

    localparam int R  = RADIX;
    localparam int R2 = RADIX * RADIX;

    logic [STEP_W-1:0] step;
    logic              adv;
    logic              last_adv;
    logic [GRP_W-1:0]  grp;
    logic              grp_end;

    cplx_t work     [N_PTS];
    cplx_t load_vec [N_PTS];
    cplx_t src      [N_PTS];
    cplx_t upd      [N_PTS];
    cplx_t nxt      [N_PTS];
    cplx_t res      [N_PTS];
    cplx_t bf_in    [RADIX];
    cplx_t bf_tw    [RADIX];
    cplx_t bf_out   [RADIX];

    ifft_step_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .step      (step),
        .in_ready  (in_ready),
        .adv       (adv),
        .last_adv  (last_adv)
    );

    ifft_twiddle_sel u_tw (
        .step (step),
        .tw   (bf_tw)
    );

    ifft_bfly4 u_bfly (
        .a  (bf_in),
        .tw (bf_tw),
        .y  (bf_out)
    );

    assign grp     = step[GRP_W-1:0];
    assign grp_end = (grp == '1);

    for (genvar p = 0; p < N_PTS; p++) begin : g_entry
        localparam int LOAD_IDX = (p % R) * R2 + ((p / R) % R) * R + p / R2;
        localparam int PERM_IDX = ((p / R) % R) * R2 + (p % R) * R + p / R2;

        assign load_vec[p].re = in_re[LOAD_IDX*SAMPLE_W +: SAMPLE_W];
        assign load_vec[p].im = in_im[LOAD_IDX*SAMPLE_W +: SAMPLE_W];
        assign src[p] = in_ready ? load_vec[p] : work[p];
        assign upd[p] = (GRP_W'(p / R) == grp) ? bf_out[p % R] : src[p];
        assign nxt[p] = grp_end ? upd[PERM_IDX] : upd[p];
        assign out_re[p*SAMPLE_W +: SAMPLE_W] = res[p].re;
        assign out_im[p*SAMPLE_W +: SAMPLE_W] = res[p].im;
    end

    for (genvar q = 0; q < RADIX; q++) begin : g_tap
        assign bf_in[q] = src[{grp, RAD_W'(q)}];
    end

    // Keep the working vector between steps; frozen while a step is held.
    always_ff @(posedge clk) begin
        if (adv && !last_adv) work <= nxt;
    end

    // Capture the finished frame when the final step runs.
    always_ff @(posedge clk) begin
        if (last_adv) res <= nxt;
    end

    // Output valid flag: set by the final step, cleared when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (last_adv)  out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

endmodule

// File: rtl/ifft64_sf_chk.sv
// Port-level protocol checker for ifft64_sf, bound to every instance.
// Assumes the synchronous active-low reset of the design.
module ifft64_sf_chk
    import ifft_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [FRAME_W-1:0] out_re,
    input logic [FRAME_W-1:0] out_im
);

    logic [7:0] busy_cnt;

    // Count busy cycles since the last accepted frame, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                            busy_cnt <= '0;
        else if (in_valid && in_ready)         busy_cnt <= '0;
        else if (!in_ready && busy_cnt != '1)  busy_cnt <= busy_cnt + 1'b1;
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r4_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (busy_cnt >= 8'(N_STEPS - 1)));

    a_r4_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> out_valid);

    a_r5_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !in_ready) |=> !in_ready);

    a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

endmodule

bind ifft64_sf ifft64_sf_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/test_ifft64_sf.sv
module test_ifft64_sf;

    localparam int  CLK_PERIOD = 10;
    localparam int  NP         = 64;
    localparam int  SW         = 16;
    localparam int  WATCHDOG   = 20000;
    localparam real TOL        = 8.0;
    localparam real TWO_PI     = 6.283185307179586;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [NP*SW-1:0] in_re;
    logic [NP*SW-1:0] in_im;
    logic             out_valid;
    logic             out_ready;
    logic [NP*SW-1:0] out_re;
    logic [NP*SW-1:0] out_im;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  xr [NP];
    int  xi [NP];
    real er [NP];
    real ei [NP];
    real sr_ [NP];
    real si_ [NP];
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ifft64_sf i_ifft64_sf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Fill the sample arrays for a pattern and compute the scaled inverse DFT.
    task automatic load(input int kind);
        for (int n = 0; n < NP; n++) begin
            xr[n] = 0;
            xi[n] = 0;
            case (kind)
                0: if (n == 0) xr[n] = 6400;
                1: if (n == 7) begin xr[n] = 6400; xi[n] = -3200; end
                2: xr[n] = $rtoi(6000.0 * $cos(TWO_PI * 3.0 * n / 64.0));
                3: begin xr[n] = 5000; xi[n] = -2000; end
                4: begin
                    seed  = seed * 1103515245 + 12345;
                    xr[n] = int'((seed >> 8) % 14001) - 7000;
                    seed  = seed * 1103515245 + 12345;
                    xi[n] = int'((seed >> 8) % 14001) - 7000;
                end
                default: begin
                    xr[n] = (n % 2 == 0) ? 8000 : -8000;
                    xi[n] = (n % 3 == 0) ? 2000 : -1000;
                end
            endcase
            in_re[n*SW +: SW] = xr[n][SW-1:0];
            in_im[n*SW +: SW] = xi[n][SW-1:0];
        end
        for (int k = 0; k < NP; k++) begin
            real ar;
            real ai;
            ar = 0.0;
            ai = 0.0;
            for (int n = 0; n < NP; n++) begin
                real ang;
                ang = TWO_PI * ((n * k) % NP) / 64.0;
                ar += xr[n] * $cos(ang) - xi[n] * $sin(ang);
                ai += xr[n] * $sin(ang) + xi[n] * $cos(ang);
            end
            er[k] = ar / 64.0;
            ei[k] = ai / 64.0;
        end
    endtask

    // Compare all 64 output bins against the current or saved expectation.
    task automatic check_frame(input string req, input bit use_saved);
        int bad;
        bad = -1;
        for (int k = 0; k < NP; k++) begin
            real gr;
            real gi;
            real xr_e;
            real xi_e;
            gr   = $itor($signed(out_re[k*SW +: SW]));
            gi   = $itor($signed(out_im[k*SW +: SW]));
            xr_e = use_saved ? sr_[k] : er[k];
            xi_e = use_saved ? si_[k] : ei[k];
            if (bad < 0 && (gr - xr_e > TOL || xr_e - gr > TOL || gi - xi_e > TOL || xi_e - gi > TOL)) begin
                bad = k;
                n_fail++;
                $display("FAIL %s: bin %0d actual (%0.0f,%0.0f) expected (%0.1f,%0.1f)",
                         req, k, gr, gi, xr_e, xi_e);
            end
        end
        n_checks++;
    endtask

    // Offer one frame, optionally with junk offered while busy, and check it.
    task automatic run_frame(input int kind, input bit junk);
        int lat;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        load(kind);
        in_valid = 1'b1;
        @(negedge clk);
        lat = 1;
        check_bit("R2 in_ready low after accept", in_ready, 1'b0);
        if (junk) begin
            in_re = ~in_re;
            in_im = {NP{16'sd1234}};
        end else begin
            in_valid = 1'b0;
        end
        while (!out_valid && lat < 300) begin
            @(negedge clk);
            lat++;
            if (lat == 47) in_valid = 1'b0;
        end
        check_int("R4 latency", lat, 48);
        check_bit("R1 in_ready at result", in_ready, 1'b1);
        check_frame(junk ? "R8 result with busy junk" : "R3 inverse transform", 1'b0);
        @(negedge clk);
        check_bit("R6 drained", out_valid, 1'b0);
        check_bit("R8 no extra frame", in_ready, 1'b1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        in_re     = '0;
        in_im     = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 reset in_ready", in_ready, 1'b1);
        check_bit("R1 reset out_valid", out_valid, 1'b0);

        for (int kind = 0; kind < 6; kind++) run_frame(kind, kind == 3);

        // Frame A is left waiting; frame B runs into a held final step.
        out_ready = 1'b0;
        load(4);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check_int("R4 latency before stall", lat, 48);
        check_frame("R3 frame A", 1'b0);
        for (int k = 0; k < NP; k++) begin
            sr_[k] = er[k];
            si_[k] = ei[k];
        end
        load(2);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (70) @(negedge clk);
        check_bit("R5 held step keeps in_ready low", in_ready, 1'b0);
        check_bit("R6 out_valid held", out_valid, 1'b1);
        check_frame("R6 frame A unchanged", 1'b1);
        out_ready = 1'b1;
        @(negedge clk);
        check_bit("R7 no gap in out_valid", out_valid, 1'b1);
        check_frame("R7 frame B replaces A", 1'b0);
        check_bit("R5 engine idle after release", in_ready, 1'b1);
        @(negedge clk);
        check_bit("R6 drained after B", out_valid, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule